// File: doc/BRIEF.md
# March C- Memory Self-Test Controller

This block runs a six-phase March C- sequence over a window of memory words and reports what it finds. Software or a boot sequencer sets a first address, an exclusive last address, a data background such as all ones or alternating bits, and a repeat count. It then pulses start. The controller drives a simple synchronous memory port. A request is taken in the cycle it is raised. A read answers with a single-cycle valid strobe after one or more cycles. Only one read is in flight at any time.

Each phase has a fixed address direction, a fixed expected read value and a fixed write value. In a read-modify phase, a word is written only after its read data has returned and been compared. Mismatches update a saturating error counter and a one-shot capture of the first failure. They never stop the run. The current phase number is visible while the run is in progress.

Top module: `march_bist_ctrl`

## Requirements
- R1: After reset, busy_o, done_o, phase_o, err_cnt_o, fail_valid_o and mem_req_o are all 0.
- R2: Phase 1 visits start..end-1 in ascending order and writes P to each word, with mem_we_o=1 meaning write.
- R3: Phase 2 visits words in ascending order. For each word it reads expecting P, then writes ~P.
- R4: Phase 3 visits words in ascending order. For each word it reads expecting ~P, then writes P.
- R5: Phase 4 visits words in descending order from end-1 down to start. For each word it reads expecting P, then writes ~P.
- R6: Phase 5 visits words in descending order. For each word it reads expecting ~P, then writes P.
- R7: Phase 6 visits words in ascending order and only reads, expecting P.
- R8: At most one read is outstanding. The write to a word is issued in the cycle right after mem_rvalid_i returned that word's read data.
- R9: The six phases run repeat_i times in total. After the last access, done_o is high for exactly one cycle, in the cycle where busy_o has already fallen.
- R10: Each read whose data differs from the expected value adds one to err_cnt_o. The counter saturates at all ones, the run continues, and an accepted start clears the counter.
- R11: fail_valid_o rises on the first mismatch of a run. From then until the next accepted start, fail_addr_o, fail_exp_o and fail_obs_o hold that first failure.
- R12: phase_o is 1 to 6 while busy_o is 1, and 0 while it is 0.
- R13: A start with end_addr_i <= start_addr_i or with repeat_i = 0 makes no memory access. It gives done_o in the next cycle, and busy_o stays 0.
- R14: A start pulse while busy_o is 1 is ignored. The running sequence keeps its pattern and its addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only while idle |
| start_addr_i | input | ADDR_W | First word address of the window |
| end_addr_i | input | ADDR_W | Exclusive end of the window |
| pattern_i | input | DATA_W | Data background P |
| repeat_i | input | REP_W | Number of full six-phase runs |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| phase_o | output | 3 | Current phase 1..6, 0 when idle |
| err_cnt_o | output | ERR_W | Saturating mismatch count |
| fail_valid_o | output | 1 | A first failure has been captured |
| fail_addr_o | output | ADDR_W | Address of the first failure |
| fail_exp_o | output | DATA_W | Expected data of the first failure |
| fail_obs_o | output | DATA_W | Observed data of the first failure |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rvalid_i | input | 1 | Read data valid strobe |
| mem_rdata_i | input | DATA_W | Read data |

## Verification
The bench builds the block with ADDR_W=8, DATA_W=64, ERR_W=3 and REP_W=4. With an 8-bit address, a window can sit against the top of the address space, where the descending phases begin at end-1. With a 3-bit counter, saturation at 7 is reached by a single stuck bit over three repeats. The bench's memory model has a read latency that can be set per run, so both immediate and delayed read data occur. It can also force one bit of one word, which produces the two-or-three-errors-per-repeat pattern that the March phases predict.

// File: rtl/march_bist_pkg.sv
package march_bist_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_OP, ST_WAIT, ST_WR} st_e;

  localparam logic [2:0] PH_FIRST = 3'd1;
  localparam logic [2:0] PH_LAST  = 3'd6;

  // direction and data polarity per phase
  function automatic logic ph_desc(input logic [2:0] ph);
    return (ph == 3'd4) || (ph == 3'd5);
  endfunction
  function automatic logic ph_rd(input logic [2:0] ph);
    return ph != 3'd1;
  endfunction
  function automatic logic ph_wr(input logic [2:0] ph);
    return ph != 3'd6;
  endfunction
  function automatic logic ph_rd_inv(input logic [2:0] ph);
    return (ph == 3'd3) || (ph == 3'd5);
  endfunction
  function automatic logic ph_wr_inv(input logic [2:0] ph);
    return (ph == 3'd2) || (ph == 3'd4);
  endfunction
endpackage

// File: rtl/march_addr_gen.sv
module march_addr_gen #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              desc_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] addr_q;
  logic              desc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      desc_q <= 1'b0;
    end else if (load_i) begin
      addr_q <= desc_i ? hi_i - ONE : lo_i;
      desc_q <= desc_i;
    end else if (step_i) begin
      addr_q <= desc_q ? addr_q - ONE : addr_q + ONE;
    end
  end

  assign addr_o = addr_q;
  assign last_o = desc_q ? (addr_q == lo_i) : (addr_q == hi_i - ONE);
endmodule

// File: rtl/march_err_log.sv
module march_err_log #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int ERR_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              chk_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [DATA_W-1:0] obs_i,
  output logic [ERR_W-1:0]  err_cnt_o,
  output logic              first_vld_o,
  output logic [ADDR_W-1:0] first_addr_o,
  output logic [DATA_W-1:0] first_exp_o,
  output logic [DATA_W-1:0] first_obs_o
);
  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

  logic mis;
  assign mis = chk_i && (exp_i != obs_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_cnt_o    <= '0;
      first_vld_o  <= 1'b0;
      first_addr_o <= '0;
      first_exp_o  <= '0;
      first_obs_o  <= '0;
    end else if (clear_i) begin
      err_cnt_o   <= '0;
      first_vld_o <= 1'b0;
    end else if (mis) begin
      if (err_cnt_o != ERR_MAX) err_cnt_o <= err_cnt_o + ERR_W'(1);
      if (!first_vld_o) begin
        first_vld_o  <= 1'b1;
        first_addr_o <= addr_i;
        first_exp_o  <= exp_i;
        first_obs_o  <= obs_i;
      end
    end
  end

  // R10: never wraps, only clear lowers it
  a_r10_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> err_cnt_o >= $past(err_cnt_o));
  // R11: first failure held until cleared
  a_r11_first_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_vld_o && !clear_i) |=> (first_vld_o && $stable(first_addr_o) && $stable(first_obs_o)));
endmodule

// File: rtl/march_bist_ctrl.sv
module march_bist_ctrl
  import march_bist_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int ERR_W  = 16,
  parameter int REP_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [ADDR_W-1:0] end_addr_i,
  input  logic [DATA_W-1:0] pattern_i,
  input  logic [REP_W-1:0]  repeat_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [2:0]        phase_o,
  output logic [ERR_W-1:0]  err_cnt_o,
  output logic              fail_valid_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [DATA_W-1:0] fail_exp_o,
  output logic [DATA_W-1:0] fail_obs_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam logic [REP_W-1:0] REP_ONE = REP_W'(1);

  st_e               st_q, st_d;
  logic [2:0]        ph_q, ph_d;
  logic [REP_W-1:0]  rep_q, rep_d;
  logic [ADDR_W-1:0] lo_q, hi_q, cfg_lo, cfg_hi;
  logic [DATA_W-1:0] pat_q, exp_val;
  logic              done_q, done_d;
  logic              accept, empty, adv;
  logic              ag_load, ag_desc, ag_step, ag_last;
  logic [ADDR_W-1:0] ag_addr;
  logic              lg_clr, lg_chk;

  assign accept = (st_q == ST_IDLE) && start_i;
  assign empty  = (end_addr_i <= start_addr_i) || (repeat_i == '0);
  assign cfg_lo = (st_q == ST_IDLE) ? start_addr_i : lo_q;
  assign cfg_hi = (st_q == ST_IDLE) ? end_addr_i : hi_q;

  march_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ag_load),
    .desc_i (ag_desc),
    .step_i (ag_step),
    .lo_i   (cfg_lo),
    .hi_i   (cfg_hi),
    .addr_o (ag_addr),
    .last_o (ag_last)
  );

  assign exp_val = ph_rd_inv(ph_q) ? ~pat_q : pat_q;

  march_err_log #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERR_W(ERR_W)) u_log (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (lg_clr),
    .chk_i        (lg_chk),
    .addr_i       (ag_addr),
    .exp_i        (exp_val),
    .obs_i        (mem_rdata_i),
    .err_cnt_o    (err_cnt_o),
    .first_vld_o  (fail_valid_o),
    .first_addr_o (fail_addr_o),
    .first_exp_o  (fail_exp_o),
    .first_obs_o  (fail_obs_o)
  );

  // word finished this cycle
  assign adv = (st_q == ST_OP && !ph_rd(ph_q))
            || (st_q == ST_WAIT && mem_rvalid_i && !ph_wr(ph_q))
            || (st_q == ST_WR);

  always_comb begin
    st_d    = st_q;
    ph_d    = ph_q;
    rep_d   = rep_q;
    done_d  = 1'b0;
    ag_load = 1'b0;
    ag_desc = 1'b0;
    ag_step = 1'b0;
    lg_clr  = 1'b0;
    lg_chk  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        lg_clr = 1'b1;
        if (empty) begin
          done_d = 1'b1;
        end else begin
          st_d    = ST_OP;
          ph_d    = PH_FIRST;
          rep_d   = repeat_i;
          ag_load = 1'b1;
        end
      end
      ST_OP:   if (ph_rd(ph_q)) st_d = ST_WAIT;
      ST_WAIT: if (mem_rvalid_i) begin
        lg_chk = 1'b1;
        if (ph_wr(ph_q)) st_d = ST_WR;
      end
      ST_WR:   ;
      default: st_d = ST_IDLE;
    endcase
    if (adv) begin
      st_d = ST_OP;
      if (!ag_last) begin
        ag_step = 1'b1;
      end else if (ph_q != PH_LAST) begin
        ph_d    = ph_q + 3'd1;
        ag_load = 1'b1;
        ag_desc = ph_desc(ph_q + 3'd1);
      end else if (rep_q != REP_ONE) begin
        rep_d   = rep_q - REP_ONE;
        ph_d    = PH_FIRST;
        ag_load = 1'b1;
      end else begin
        st_d   = ST_IDLE;
        ph_d   = 3'd0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= 3'd0;
      rep_q  <= '0;
      done_q <= 1'b0;
      lo_q   <= '0;
      hi_q   <= '0;
      pat_q  <= '0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      rep_q  <= rep_d;
      done_q <= done_d;
      if (accept) begin
        lo_q  <= start_addr_i;
        hi_q  <= end_addr_i;
        pat_q <= pattern_i;
      end
    end
  end

  assign busy_o      = st_q != ST_IDLE;
  assign done_o      = done_q;
  assign phase_o     = ph_q;
  assign mem_req_o   = (st_q == ST_OP) || (st_q == ST_WR);
  assign mem_we_o    = (st_q == ST_WR) || (st_q == ST_OP && !ph_rd(ph_q));
  assign mem_addr_o  = ag_addr;
  assign mem_wdata_o = ph_wr_inv(ph_q) ? ~pat_q : pat_q;

  // R8: read-modify write follows returned read data
  a_r8_wr_after_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && ph_q inside {3'd2, 3'd3, 3'd4, 3'd5}) |-> $past(mem_rvalid_i));
  // R12: phase range tracks busy
  a_r12_phase_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o ? (phase_o inside {[3'd1:3'd6]}) : (phase_o == 3'd0));
  // R9: done is a single-cycle pulse while idle
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o ##1 !done_o));
  // R13: no access while idle
  a_r13_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
  // R2: accesses stay inside the window
  a_r2_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o >= lo_q && mem_addr_o < hi_q));
  // R14: configuration frozen during a run
  a_r14_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(pat_q) && $stable(lo_q) && $stable(hi_q)));
endmodule

// File: tb/march_bist_ctrl_tb_top.sv
`timescale 1ns/1ps
module march_bist_ctrl_tb_top;
  localparam int AW = 8;
  localparam int DW = 64;
  localparam int EW = 3;
  localparam int RW = 4;
  localparam int EMAX = (1 << EW) - 1;

  typedef struct {
    logic          we;
    int            addr;
    logic [DW-1:0] data;
    int            ph;
  } op_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] s_addr = '0, e_addr = '0;
  logic [DW-1:0] pat = '0;
  logic [RW-1:0] rep = '0;
  logic          busy, done, fvld, req, we;
  logic [2:0]    phase;
  logic [EW-1:0] ecnt;
  logic [AW-1:0] faddr, maddr;
  logic [DW-1:0] fexp, fobs, wdata;
  logic          rvalid;
  logic [DW-1:0] rdata;

  always #10 clk = ~clk;

  march_bist_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ERR_W(EW), .REP_W(RW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(s_addr),
    .end_addr_i(e_addr), .pattern_i(pat), .repeat_i(rep), .busy_o(busy),
    .done_o(done), .phase_o(phase), .err_cnt_o(ecnt), .fail_valid_o(fvld),
    .fail_addr_o(faddr), .fail_exp_o(fexp), .fail_obs_o(fobs),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(maddr), .mem_wdata_o(wdata),
    .mem_rvalid_i(rvalid), .mem_rdata_i(rdata)
  );

  // memory model: settable read latency, one stuck bit
  logic [DW-1:0] mem [256];
  int  lat = 1;
  bit  f_en = 1'b0;
  int  f_addr = 0, f_bit = 0;
  bit  f_val = 1'b0;
  logic pend = 1'b0;
  int  pcnt = 0;

  function automatic logic [DW-1:0] faulty(int a, logic [DW-1:0] d);
    logic [DW-1:0] r = d;
    if (f_en && a == f_addr) r[f_bit] = f_val;
    return r;
  endfunction

  assign rvalid = pend && (pcnt == 0);

  always @(posedge clk) begin
    if (req && we) mem[maddr] <= wdata;
    if (req && !we) begin
      pend  <= 1'b1;
      pcnt  <= lat - 1;
      rdata <= faulty(int'(maddr), mem[maddr]);
    end else if (pend) begin
      if (pcnt == 0) pend <= 1'b0;
      else pcnt <= pcnt - 1;
    end
  end

  // reference model
  op_t q[$];
  logic [DW-1:0] mdl [256];
  int  e_err;
  bit  e_fv;
  int  e_fa;
  logic [DW-1:0] e_fe, e_fo;

  task automatic build(int lo, int hi, logic [DW-1:0] p, int r);
    q.delete();
    e_err = 0; e_fv = 0; e_fa = 0; e_fe = '0; e_fo = '0;
    if (hi <= lo || r == 0) return;
    for (int k = 0; k < r; k++)
      for (int ph = 1; ph <= 6; ph++)
        for (int i = 0; i < hi - lo; i++) begin
          int a;
          logic [DW-1:0] ex, ob, wv;
          a = (ph == 4 || ph == 5) ? hi - 1 - i : lo + i;
          if (ph != 1) begin
            ex = (ph == 3 || ph == 5) ? ~p : p;
            ob = faulty(a, mdl[a]);
            q.push_back('{1'b0, a, '0, ph});
            if (ob != ex) begin
              if (e_err < EMAX) e_err++;
              if (!e_fv) begin e_fv = 1; e_fa = a; e_fe = ex; e_fo = ob; end
            end
          end
          if (ph != 6) begin
            wv = (ph == 2 || ph == 4) ? ~p : p;
            mdl[a] = wv;
            q.push_back('{1'b1, a, wv, ph});
          end
        end
  endtask

  function automatic string tag(int ph);
    case (ph)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  // per-clock comparison against the model stream
  int s_chk = 0, s_fail = 0;
  logic prev_rv = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      s_chk++;
      if (busy ? (phase < 3'd1 || phase > 3'd6) : (phase != 3'd0)) begin
        s_fail++;
        $display("FAIL R12 phase act=%0d exp=%s", phase, busy ? "1..6" : "0");
      end
      if (req) begin
        s_chk++;
        if (q.size() == 0) begin
          s_fail++;
          $display("FAIL R13 unexpected access act addr=%0d we=%0b exp=none", maddr, we);
        end else begin
          op_t h;
          h = q.pop_front();
          if (we != h.we || int'(maddr) != h.addr || int'(phase) != h.ph ||
              (h.we && wdata != h.data)) begin
            s_fail++;
            $display("FAIL %s op act=we%0b a%0d ph%0d d%h exp=we%0b a%0d ph%0d d%h",
                     tag(h.ph), we, maddr, phase, wdata, h.we, h.addr, h.ph, h.data);
          end
          if (we && h.ph >= 2 && h.ph <= 5) begin
            s_chk++;
            if (!prev_rv) begin
              s_fail++;
              $display("FAIL R8 write without prior read data act=%0b exp=1", prev_rv);
            end
          end
        end
      end
      prev_rv = rvalid;
    end
  end

  int m_chk = 0, m_fail = 0;
  bit wd_hit = 0;

  task automatic chk(bit ok, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    m_chk++;
    if (!ok) begin
      m_fail++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", m_chk + s_chk + wd_hit, m_fail + s_fail + wd_hit);
    $finish;
  endtask

  task automatic run(int lo, int hi, logic [DW-1:0] p, int r, int l, int poke);
    lat = l;
    build(lo, hi, p, r);
    @(negedge clk);
    start = 1'b1; s_addr = AW'(lo); e_addr = AW'(hi); pat = p; rep = RW'(r);
    @(negedge clk);
    start = 1'b0;
    if (hi <= lo || r == 0) begin
      chk(done && !busy, "R13 empty start done/busy", {done, busy}, 2'b10);
    end else begin
      for (int i = 0; i < poke; i++) @(negedge clk);
      if (poke > 0) begin
        // R14: ignored restart with different settings
        start = 1'b1; pat = ~p; s_addr = '0; e_addr = AW'(hi + 1); rep = RW'(1);
        @(negedge clk);
        start = 1'b0;
      end
      while (!done) @(negedge clk);
      chk(!busy, "R9 busy low with done", busy, 0);
      chk(q.size() == 0, "R9 all repeats issued (ops left)", q.size(), 0);
    end
    chk(ecnt == EW'(e_err), "R10 error count", ecnt, e_err);
    chk(fvld == e_fv, "R11 first valid", fvld, e_fv);
    if (e_fv) begin
      chk(int'(faddr) == e_fa, "R11 first addr", faddr, e_fa);
      chk(fexp == e_fe, "R11 first expected", fexp, e_fe);
      chk(fobs == e_fo, "R11 first observed", fobs, e_fo);
    end
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    wd_hit = 1;
    $display("FAIL watchdog expired act=hung exp=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({busy, done, phase, ecnt, fvld, req} == '0, "R1 reset outputs",
        {busy, done, phase, ecnt, fvld, req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, phase, req} == '0, "R1 idle after reset", {busy, done, phase, req}, 0);
    // all ones, clean
    run(4, 12, {DW{1'b1}}, 1, 1, 0);
    // alternating bits, stuck-at-0 on bit 0, slow reads
    f_en = 1; f_addr = 2; f_bit = 0; f_val = 0;
    run(0, 5, {(DW/4){4'h5}}, 2, 3, 0);
    // saturation with stuck-at-1 on top bit, ignored restart mid-run
    f_addr = 9; f_bit = DW - 1; f_val = 1;
    run(6, 14, 64'h0123_4567_89ab_cdef, 3, 1, 40);
    // clean run after errors: counter cleared (R10)
    f_en = 0;
    run(1, 4, 64'hf0f0_0000_ffff_1234, 1, 2, 0);
    // single word at top of space, descending start at end-1
    run(254, 255, '0, 2, 2, 0);
    // R13: empty window and zero repeats
    run(7, 7, 64'h1, 1, 1, 0);
    run(3, 8, 64'h2, 0, 1, 0);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule